// File: doc/BRIEF.md
# Memory Pattern Scrubber

The scrubber is a hardware engine that owns the master side of a small single-port synchronous RAM. When started, it writes a known pattern into every location of an address window. It then keeps sweeping that window until it is aborted. On each pass it reads every location and compares the value with the pattern it expects there. A location that no longer holds the right value is rewritten with the expected value, and the engine keeps going. It does not stop at the first fault.

Each corrected fault produces a record in a small report FIFO that a consumer drains over a valid/ready handshake. The record holds the address, the value read back, the value expected, and a time tag. The time tag comes from a free-running counter inside the block. A saturating fault counter and a once-per-pass pulse show how the engine is progressing.

The engine has two modes, chosen when it is started:
- **Data-window mode:** a parameterised window, 0x20 to 0xFF by default, holding one fixed byte.
- **Bank mode:** four 8-byte banks at the bottom of the address space, with alternating patterns.

Top module: `mem_scrubber`

## Requirements
- R1: While reset is held, and after it until a start, `busy`, `ram_en`, `err_valid` and `sweep_done` are 0 and `err_count` is 0.
- R2: A start with `mode_bank`=0 writes the pattern (default 0x55) to each address from the window low bound to the high bound (default 0x20 to 0xFF), one write per cycle, in ascending order.
- R3: A start with `mode_bank`=1 fills addresses 0x00 to 0x1F. The expected value is 0xAA where address bits [4:3] are 0 or 2, and 0x55 where they are 1 or 3. The mode is latched at start.
- R4: After the fill, the engine sweeps the same window forever in ascending order, wrapping from the high bound back to the low bound. A location that matches takes two cycles: a read cycle, then a compare cycle in which `ram_en` is 0. The RAM returns read data one cycle after the read.
- R5: When the compare finds a mismatch and a record is accepted, the next cycle writes the expected value back to the same address. A faulty location therefore takes three cycles.
- R6: A record carries the address, the observed byte, the expected byte and the time tag. The time tag is the value of a 32-bit counter in the compare cycle. The counter is 0 in the first cycle after reset and increases by one every clock.
- R7: If the report FIFO is full when a mismatch is found, no record is pushed and nothing is written back. The same address is read again, and the engine does not move on until the record fits, so no fault is lost.
- R8: `err_valid` is high while the FIFO holds a record. The head fields stay stable until `err_ready` is high, and records leave in the order they were found.
- R9: `err_count` increases by one for each accepted record and saturates at its maximum value. A parameter sets its width.
- R10: `sweep_done` is a one-cycle pulse, raised in the cycle after the engine leaves the high-bound address to wrap back to the low bound during a sweep.
- R11: `abort` returns the engine to idle at the next edge, and the RAM is no longer accessed from then on. `abort` wins over a `start` in the same cycle. The FIFO contents and `err_count` are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin fill and sweep when idle |
| abort | input | 1 | Return to idle |
| mode_bank | input | 1 | Selects bank mode at start |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data, one cycle after a read |
| err_valid | output | 1 | Report record available |
| err_ready | input | 1 | Consumer takes the head record |
| err_addr | output | ADDR_W | Record: faulty address |
| err_obs | output | DATA_W | Record: value read |
| err_exp | output | DATA_W | Record: value expected |
| err_tag | output | TAG_W | Record: time tag |
| err_count | output | CNT_W | Saturating fault count |
| sweep_done | output | 1 | One-cycle pulse per completed pass |
| busy | output | 1 | Engine is filling or sweeping |

## Verification
The bench corrupts RAM cells during sweeps, including the high-bound address where the wrap happens. A design that mishandles the wrap would skip or repeat a cell, or miss the once-per-pass pulse. It holds the consumer off until the FIFO fills. A design that drops or overwrites a record would then show a wrong head record or a count that is too high, and one that writes back without a record would clear a fault that was never reported. It keeps injecting faults until the counter saturates, where a wrapping counter would read back a small value. It also raises abort together with start, and runs bank mode to check the per-bank pattern and its bit decoding.

// File: rtl/mscrub_pkg.sv
package mscrub_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FILL,
      ST_READ,
      ST_CMP,
      ST_FIX
   } scrub_st_e;
endpackage

// File: rtl/mscrub_counter.sv
module mscrub_counter #(
   parameter int unsigned W        = 32,
   parameter bit          SATURATE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] TOP = '1;

   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n)                q <= '0;
            else if (inc && q != TOP)  q <= q + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)    q <= '0;
            else if (inc)  q <= q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/mscrub_fifo.sv
module mscrub_fifo #(
   parameter int unsigned W     = 56,
   parameter int unsigned DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]  slot_q [DEPTH];
   logic [PW-1:0] wr_q, rd_q;
   logic [PW:0]   fill_q;
   logic          do_push, do_pop;

   assign full    = (fill_q == (PW+1)'(DEPTH));
   assign empty   = (fill_q == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = slot_q[rd_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q   <= '0;
         rd_q   <= '0;
         fill_q <= '0;
      end else begin
         if (do_push) wr_q <= wr_q + 1'b1;
         if (do_pop)  rd_q <= rd_q + 1'b1;
         if (do_push && !do_pop)      fill_q <= fill_q + 1'b1;
         else if (do_pop && !do_push) fill_q <= fill_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) slot_q[wr_q] <= din;
   end
endmodule

// File: rtl/mscrub_engine.sv
module mscrub_engine
   import mscrub_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned WIN_LO  = 32'h20,
   parameter int unsigned WIN_HI  = 32'hFF,
   parameter int unsigned PATTERN = 32'h55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic              mode_bank,
   input  logic              fifo_full,
   output logic              ram_en,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              rec_push,
   output logic [DATA_W-1:0] rec_exp,
   output logic              sweep_done,
   output logic              busy
);
   localparam logic [ADDR_W-1:0] LO_DATA = ADDR_W'(WIN_LO);
   localparam logic [ADDR_W-1:0] HI_DATA = ADDR_W'(WIN_HI);
   localparam logic [ADDR_W-1:0] HI_BANK = ADDR_W'(31);
   localparam logic [DATA_W-1:0] PAT_D   = DATA_W'(PATTERN);
   localparam logic [DATA_W-1:0] PAT_A   = {(DATA_W/2){2'b10}};
   localparam logic [DATA_W-1:0] PAT_B   = ~PAT_A;

   scrub_st_e         st_q;
   logic [ADDR_W-1:0] addr_q, lo, hi;
   logic              mode_q, at_hi, mism;

   assign lo    = mode_q ? '0 : LO_DATA;
   assign hi    = mode_q ? HI_BANK : HI_DATA;
   assign at_hi = (addr_q == hi);

   // bank index is address bits [4:3]; even banks take PAT_A
   assign rec_exp = mode_q ? (addr_q[3] ? PAT_B : PAT_A) : PAT_D;
   assign mism    = (st_q == ST_CMP) && (ram_rdata != rec_exp);
   assign rec_push = mism && !fifo_full && !abort;

   assign busy      = (st_q != ST_IDLE);
   assign ram_en    = (st_q == ST_FILL) || (st_q == ST_READ) || (st_q == ST_FIX);
   assign ram_we    = (st_q == ST_FILL) || (st_q == ST_FIX);
   assign ram_addr  = addr_q;
   assign ram_wdata = rec_exp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         addr_q     <= '0;
         mode_q     <= 1'b0;
         sweep_done <= 1'b0;
      end else begin
         sweep_done <= 1'b0;
         if (abort) begin
            st_q <= ST_IDLE;
         end else begin
            unique case (st_q)
               ST_IDLE: if (start) begin
                  mode_q <= mode_bank;
                  addr_q <= mode_bank ? '0 : LO_DATA;
                  st_q   <= ST_FILL;
               end
               ST_FILL: begin
                  if (at_hi) begin
                     addr_q <= lo;
                     st_q   <= ST_READ;
                  end else begin
                     addr_q <= addr_q + 1'b1;
                  end
               end
               ST_READ: st_q <= ST_CMP;
               ST_CMP: begin
                  if (!mism) begin
                     addr_q     <= at_hi ? lo : addr_q + 1'b1;
                     sweep_done <= at_hi;
                     st_q       <= ST_READ;
                  end else if (!fifo_full) begin
                     st_q <= ST_FIX;
                  end else begin
                     st_q <= ST_READ;
                  end
               end
               ST_FIX: begin
                  addr_q     <= at_hi ? lo : addr_q + 1'b1;
                  sweep_done <= at_hi;
                  st_q       <= ST_READ;
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/mem_scrubber.sv
module mem_scrubber #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned TAG_W      = 32,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned FIFO_DEPTH = 4,
   parameter int unsigned WIN_LO     = 32'h20,
   parameter int unsigned WIN_HI     = 32'hFF,
   parameter int unsigned PATTERN    = 32'h55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic              mode_bank,
   output logic              ram_en,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              err_valid,
   input  logic              err_ready,
   output logic [ADDR_W-1:0] err_addr,
   output logic [DATA_W-1:0] err_obs,
   output logic [DATA_W-1:0] err_exp,
   output logic [TAG_W-1:0]  err_tag,
   output logic [CNT_W-1:0]  err_count,
   output logic              sweep_done,
   output logic              busy
);
   localparam int unsigned REC_W = ADDR_W + 2*DATA_W + TAG_W;

   generate
      if (WIN_LO > WIN_HI) begin : g_bad_window
         $error("window low bound above high bound");
      end
      if (WIN_HI >= (1 << ADDR_W)) begin : g_bad_hi
         $error("window high bound outside address space");
      end
      if (ADDR_W < 5) begin : g_bad_aw
         $error("bank mode needs at least 5 address bits");
      end
      if ((DATA_W % 2) != 0) begin : g_bad_dw
         $error("data width must be even for alternating patterns");
      end
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("report FIFO depth must be a power of two, at least 2");
      end
   endgenerate

   logic              rec_push, fifo_full, fifo_empty;
   logic [DATA_W-1:0] rec_exp;
   logic [TAG_W-1:0]  tag_now;
   logic [REC_W-1:0]  rec_in, rec_out;

   mscrub_counter #(.W(TAG_W), .SATURATE(1'b0)) u_tag (
      .clk(clk), .rst_n(rst_n), .inc(1'b1), .q(tag_now)
   );

   mscrub_counter #(.W(CNT_W), .SATURATE(1'b1)) u_errcnt (
      .clk(clk), .rst_n(rst_n), .inc(rec_push), .q(err_count)
   );

   mscrub_engine #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_LO(WIN_LO),
      .WIN_HI(WIN_HI), .PATTERN(PATTERN)
   ) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
      .mode_bank(mode_bank), .fifo_full(fifo_full),
      .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .rec_push(rec_push), .rec_exp(rec_exp),
      .sweep_done(sweep_done), .busy(busy)
   );

   assign rec_in = {ram_addr, ram_rdata, rec_exp, tag_now};

   mscrub_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(rec_push), .din(rec_in),
      .pop(err_ready), .dout(rec_out), .full(fifo_full), .empty(fifo_empty)
   );

   assign err_valid = !fifo_empty;
   assign {err_addr, err_obs, err_exp, err_tag} = rec_out;
endmodule

// File: rtl/mscrub_chk.sv
module mscrub_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned TAG_W  = 32,
   parameter int unsigned CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              abort,
   input logic              busy,
   input logic              ram_en,
   input logic              ram_we,
   input logic [ADDR_W-1:0] ram_addr,
   input logic [DATA_W-1:0] ram_wdata,
   input logic              err_valid,
   input logic              err_ready,
   input logic [ADDR_W-1:0] err_addr,
   input logic [DATA_W-1:0] err_obs,
   input logic [DATA_W-1:0] err_exp,
   input logic [TAG_W-1:0]  err_tag,
   input logic [CNT_W-1:0]  err_count,
   input logic              sweep_done,
   input logic              rec_push,
   input logic [DATA_W-1:0] rec_exp
);
   // R11
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!busy && !ram_en));

   // R8
   head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid && !err_ready) |=>
         (err_valid && $stable({err_addr, err_obs, err_exp, err_tag})));

   // R9
   cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (err_count >= $past(err_count)));

   // R5
   fix_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_push |=> (ram_we && ram_addr == $past(ram_addr)
                    && ram_wdata == $past(rec_exp)));

   // R4
   cmp_idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_push |-> !ram_en);

   // R10
   sweep_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_done |=> !sweep_done);
endmodule

bind mem_scrubber mscrub_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .abort(abort), .busy(busy),
   .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
   .ram_wdata(ram_wdata), .err_valid(err_valid), .err_ready(err_ready),
   .err_addr(err_addr), .err_obs(err_obs), .err_exp(err_exp),
   .err_tag(err_tag), .err_count(err_count), .sweep_done(sweep_done),
   .rec_push(rec_push), .rec_exp(rec_exp)
);

// File: tb/mem_scrubber_tb.sv
`timescale 1ns/1ps
module mem_scrubber_tb;
   localparam int DEPTH = 2;
   localparam int CMAX  = 7;
   localparam int LIMIT = 150000;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n, start, abort, mode_bank, err_ready;
   logic        ram_en, ram_we, err_valid, sweep_done, busy;
   logic [7:0]  ram_addr, ram_wdata, ram_rdata, err_addr, err_obs, err_exp;
   logic [31:0] err_tag;
   logic [2:0]  err_count;

   mem_scrubber #(.CNT_W(3), .FIFO_DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
      .mode_bank(mode_bank), .ram_en(ram_en), .ram_we(ram_we),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .err_valid(err_valid), .err_ready(err_ready), .err_addr(err_addr),
      .err_obs(err_obs), .err_exp(err_exp), .err_tag(err_tag),
      .err_count(err_count), .sweep_done(sweep_done), .busy(busy)
   );

   logic [7:0] mem [256];
   always @(posedge clk) begin
      if (ram_en) begin
         if (ram_we) mem[ram_addr] <= ram_wdata;
         else        ram_rdata <= mem[ram_addr];
      end
   end

   int nchk = 0, nfail = 0, cyc = 0, sd_seen = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   localparam int S_IDLE = 0, S_FILL = 1, S_READ = 2, S_CMP = 3, S_FIX = 4;
   int          m_st;
   logic [7:0]  m_addr, m_rdata;
   bit          m_mode, m_sd;
   int unsigned m_tag;
   int          m_cnt;
   logic [55:0] m_q[$];

   function automatic logic [7:0] pat(input bit md, input logic [7:0] a);
      if (!md) return 8'h55;
      return a[3] ? 8'h55 : 8'hAA;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_st = S_IDLE; m_addr = 0; m_mode = 0; m_sd = 0;
         m_tag = 0; m_cnt = 0; m_q.delete(); m_rdata = 0;
      end else begin
         logic [7:0] e, lo, hi;
         bit full, push;
         e    = pat(m_mode, m_addr);
         lo   = m_mode ? 8'h00 : 8'h20;
         hi   = m_mode ? 8'h1F : 8'hFF;
         full = (m_q.size() == DEPTH);
         push = (m_st == S_CMP) && (m_rdata != e) && !full && !abort;
         if (m_q.size() > 0 && err_ready) void'(m_q.pop_front());
         if (push) begin
            m_q.push_back({m_addr, m_rdata, e, m_tag});
            if (m_cnt < CMAX) m_cnt++;
         end
         m_sd = 0;
         if (abort) m_st = S_IDLE;
         else case (m_st)
            S_IDLE: if (start) begin
               m_mode = mode_bank; m_addr = mode_bank ? 8'h00 : 8'h20; m_st = S_FILL;
            end
            S_FILL: if (m_addr == hi) begin m_addr = lo; m_st = S_READ; end
                    else m_addr++;
            S_READ: begin m_rdata = mem[m_addr]; m_st = S_CMP; end
            S_CMP: begin
               if (m_rdata == e) begin
                  m_sd = (m_addr == hi);
                  m_addr = (m_addr == hi) ? lo : m_addr + 1;
                  m_st = S_READ;
               end else if (!full) m_st = S_FIX;
               else m_st = S_READ;
            end
            default: begin
               m_sd = (m_addr == hi);
               m_addr = (m_addr == hi) ? lo : m_addr + 1;
               m_st = S_READ;
            end
         endcase
         m_tag++;
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         string rq;
         bit en_x, we_x;
         en_x = (m_st == S_FILL) || (m_st == S_READ) || (m_st == S_FIX);
         we_x = (m_st == S_FILL) || (m_st == S_FIX);
         rq = (m_st == S_FILL) ? (m_mode ? "R3" : "R2") : "R4";
         if (sweep_done) sd_seen++;
         chk(busy == (m_st != S_IDLE), "R11 busy", busy, m_st != S_IDLE);
         chk(ram_en == en_x, {rq, " ram_en"}, ram_en, en_x);
         chk(ram_we == we_x, {rq, " ram_we"}, ram_we, we_x);
         if (en_x) chk(ram_addr == m_addr, {rq, " ram_addr"}, ram_addr, m_addr);
         if (we_x) chk(ram_wdata == pat(m_mode, m_addr),
                       (m_st == S_FIX) ? "R5 wdata" : {rq, " wdata"},
                       ram_wdata, pat(m_mode, m_addr));
         chk(sweep_done == m_sd, "R10 sweep_done", sweep_done, m_sd);
         chk(err_count == 3'(m_cnt), "R9 err_count", err_count, m_cnt);
         chk(err_valid == (m_q.size() > 0), "R8 err_valid", err_valid, m_q.size() > 0);
         if (m_q.size() > 0)
            chk({err_addr, err_obs, err_exp, err_tag} == m_q[0], "R6 record",
                {err_addr, err_obs, err_exp, err_tag}, m_q[0]);
      end
   end

   // watchdog
   always @(posedge clk) begin
      if (cyc > LIMIT) begin
         nfail++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cyc, LIMIT);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_start(input bit md);
      mode_bank = md; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   function automatic int window_bad();
      int bad = 0;
      for (int a = 8'h20; a <= 8'hFF; a++) if (mem[a] != 8'h55) bad++;
      return bad;
   endfunction

   initial begin
      for (int a = 0; a < 256; a++) mem[a] <= 8'h00;
      rst_n = 1'b0; start = 1'b0; abort = 1'b0; mode_bank = 1'b0; err_ready = 1'b1;
      idle(3);
      // R1 reset state
      chk(!busy && !ram_en, "R1 idle in reset", {busy, ram_en}, 0);
      chk(!err_valid && err_count == 0 && !sweep_done, "R1 outputs in reset",
          {err_valid, err_count, sweep_done}, 0);
      rst_n = 1'b1;
      idle(4);
      chk(!busy && !ram_en, "R1 idle without start", {busy, ram_en}, 0);

      // R2 fill, R4 sweep, R5 writeback, R10 pulses
      pulse_start(1'b0);
      idle(260);
      chk(window_bad() == 0, "R2 window filled", window_bad(), 0);
      mem[8'h40] <= 8'h12;
      mem[8'hFF] <= 8'h00;
      idle(500);
      chk(window_bad() == 0, "R5 faults corrected", window_bad(), 0);
      chk(sd_seen >= 1, "R10 pulses seen", sd_seen, 1);

      // R7 full FIFO stalls without loss
      err_ready = 1'b0;
      @(negedge clk);
      mem[8'h30] <= 8'h01;
      mem[8'h50] <= 8'h02;
      mem[8'h70] <= 8'h03;
      idle(600);
      chk(err_count == 3'd4, "R7 only two records accepted", err_count, 4);
      chk(window_bad() == 1, "R7 stalled cell not rewritten", window_bad(), 1);
      chk(busy && err_valid, "R7 still running, head held", {busy, err_valid}, 3);
      err_ready = 1'b1;
      idle(500);
      chk(err_count == 3'd5, "R7 stalled fault reported", err_count, 5);
      chk(window_bad() == 0, "R7 all corrected", window_bad(), 0);

      // R9 saturation
      for (int k = 0; k < 5; k++) mem[8'h21 + k] <= 8'hAA;
      idle(500);
      chk(err_count == 3'(CMAX), "R9 saturated", err_count, CMAX);

      // R11 abort beats start
      abort = 1'b1; start = 1'b1;
      @(negedge clk);
      abort = 1'b0; start = 1'b0;
      chk(!busy && !ram_en, "R11 aborted", {busy, ram_en}, 0);
      idle(5);
      chk(!busy && !ram_en, "R11 stays idle", {busy, ram_en}, 0);

      // R3 bank mode
      pulse_start(1'b1);
      idle(40);
      for (int a = 0; a < 32; a++)
         chk(mem[a] == ((a[3]) ? 8'h55 : 8'hAA), "R3 bank pattern", mem[a],
             a[3] ? 8'h55 : 8'hAA);
      mem[8'h12] <= 8'h00;
      idle(120);
      chk(mem[8'h12] == 8'hAA, "R3 bank 2 corrected", mem[8'h12], 8'hAA);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      idle(3);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule